// File: doc/BRIEF.md
# Gapped Data-Link Clock Extractor

This block sits beside a T1 or E1 line-rate bit stream, clocked by the line clock at one bit per cycle. It counts bit positions from a frame-start marker and picks out the bits that belong to an embedded data link. Two masks decide which bits these are. A 32-bit slot mask selects time slots, and an 8-bit mask selects bit positions inside every selected slot. For each picked bit the block emits a gapped clock pulse, and that pulse lies wholly inside the low half of the line clock.

On the transmit side, an external data-link source drives a bit while the gapped pulse is high. The block captures it on the pulse's falling edge and puts it in place of the stream bit at that position. Every other bit passes through unchanged. On the receive side, every received bit goes to the serial output unchanged. A marker, aligned with that output, flags the bits that belong to the link. The frame-start marker and the mode input come from the framer. The block does no framing and no line coding.

Top module: `dlgc_gap_clock`

## Requirements
- R1: After reset, gclk_o, rx_mark_o, rx_data_o and tx_data_o are 0. No bit is marked or pulsed until the first frame_start_i has been sampled.
- R2: gclk_o is high only while clk_i is low, and only in the cycle that carries a selected bit. While clk_i is high, gclk_o is low.
- R3: frame_start_i high marks the bit presented in that cycle as bit 0 of a frame. In E1 mode (e1_mode_i=1), bit k belongs to slot k/8, at position k%8 within the slot. A bit is selected when slot_en_i[slot] and bit_en_i[position] are both 1. Position 0 is the first bit of the slot.
- R4: In T1 mode (e1_mode_i=0), bit 0 is the framing bit and is never selected. Bit k≥1 belongs to slot (k-1)/8, at position (k-1)%8. slot_en_i bits 24 to 31 have no effect.
- R5: Without a new frame_start_i, positions wrap by themselves after 193 bits (T1) or 256 bits (E1).
- R6: A frame_start_i that arrives in the middle of a frame restarts the count at bit 0 in that cycle.
- R7: rx_data_o equals rx_data_i one cycle later. rx_mark_o is high in that same cycle exactly when the bit was selected, and gclk_o pulses in the low half of that cycle.
- R8: tx_data_o shows the bit presented on tx_data_i two cycles later. If that bit was selected, tx_data_o instead shows dl_data_i as captured at the rising clk_i edge that ends the gapped pulse.
- R9: Over one frame, the number of gapped pulses equals the number of enabled slots that exist in the mode times the number of enabled bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-rate bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e1_mode_i | input | 1 | 1 = E1 (256 bits per frame), 0 = T1 (193 bits per frame) |
| frame_start_i | input | 1 | High with bit 0 of a frame |
| slot_en_i | input | 32 | Per-slot select mask |
| bit_en_i | input | 8 | Bit-in-slot select mask, bit 0 = first bit of the slot |
| tx_data_i | input | 1 | Transmit stream bit |
| dl_data_i | input | 1 | External data-link bit, captured at the end of a gapped pulse |
| rx_data_i | input | 1 | Received stream bit |
| gclk_o | output | 1 | Gapped data-link clock |
| tx_data_o | output | 1 | Transmit stream with link bits merged in |
| rx_data_o | output | 1 | Received stream, delayed one cycle |
| rx_mark_o | output | 1 | High on rx_data_o bits that belong to the link |

## Verification
A frame wrap and a frame_start_i can land on the same bit. The mid-frame restart in the bench forces this: a marker arrives at bit 100 of an E1 frame, and a later marker is placed exactly on the natural wrap. In both cases the reference model restarts at bit 0, and every following pulse, mark and merged bit is compared against it. Within one cycle the transmit merge and the receive mark of the same position also coincide. Random tx_data_i and dl_data_i values are used so that a swap between the pass-through path and the replacement path shows up on tx_data_o.

// File: rtl/dlgc_pkg.sv
package dlgc_pkg;
  localparam int unsigned SLOTS_MAX = 32;
  localparam int unsigned SLOT_BITS = 8;
  localparam int unsigned T1_SLOTS  = 24;

  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/dlgc_pos_counter.sv
module dlgc_pos_counter
  import dlgc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = SLOTS_MAX,
  parameter int unsigned BITS_SLOT  = SLOT_BITS,
  parameter int unsigned SHORT_SLOTS = T1_SLOTS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W  = $clog2(BITS_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              frame_start_i,
  output logic              locked_d_o,
  output logic              fbit_d_o,
  output logic [SLOT_W-1:0] slot_d_o,
  output logic [BIT_W-1:0]  bit_d_o
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_SLOT - 1);
  localparam logic [SLOT_W-1:0] LONG_LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SHRT_LAST = SLOT_W'(SHORT_SLOTS - 1);

  line_mode_e        mode;
  logic              locked_q, fbit_q;
  logic [SLOT_W-1:0] slot_q, slot_last;
  logic [BIT_W-1:0]  bit_q;
  logic              fbit_d;
  logic [SLOT_W-1:0] slot_d;
  logic [BIT_W-1:0]  bit_d;

  assign mode      = line_mode_e'(e1_mode_i);
  assign slot_last = (mode == MODE_E1) ? LONG_LAST : SHRT_LAST;

  // position of the bit presented in this cycle
  always_comb begin
    fbit_d = fbit_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (frame_start_i) begin
      fbit_d = (mode == MODE_T1);
      slot_d = '0;
      bit_d  = '0;
    end else if (fbit_q) begin
      fbit_d = 1'b0;
    end else if (bit_q == BIT_LAST) begin
      bit_d = '0;
      if (slot_q == slot_last) begin
        slot_d = '0;
        fbit_d = (mode == MODE_T1);
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end else begin
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      fbit_q   <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      locked_q <= locked_q | frame_start_i;
      fbit_q   <= fbit_d;
      slot_q   <= slot_d;
      bit_q    <= bit_d;
    end
  end

  assign locked_d_o = locked_q | frame_start_i;
  assign fbit_d_o   = fbit_d;
  assign slot_d_o   = slot_d;
  assign bit_d_o    = bit_d;
endmodule

// File: rtl/dlgc_slot_select.sv
module dlgc_slot_select
  import dlgc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOTS_MAX,
  parameter int unsigned BITS_SLOT = SLOT_BITS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W  = $clog2(BITS_SLOT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 locked_i,
  input  logic                 fbit_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [NUM_SLOTS-1:0] slot_en_i,
  input  logic [BITS_SLOT-1:0] bit_en_i,
  output logic                 sel_o
);
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [BITS_SLOT-1:0] bit_hit;
  logic                 sel_d, sel_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit[s] = slot_en_i[s] && (slot_i == SLOT_W'(s));
  end
  for (genvar b = 0; b < BITS_SLOT; b++) begin : g_bit
    assign bit_hit[b] = bit_en_i[b] && (bit_i == BIT_W'(b));
  end

  assign sel_d = locked_i && !fbit_i && (|slot_hit) && (|bit_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/dlgc_tx_merge.sv
module dlgc_tx_merge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic tx_data_i,
  input  logic dl_data_i,
  output logic tx_data_o
);
  logic tx_s_q, tx_o_q;

  // stage 1 aligns the stream bit with sel_i; stage 2 captures at gapped fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_s_q <= 1'b0;
      tx_o_q <= 1'b0;
    end else begin
      tx_s_q <= tx_data_i;
      tx_o_q <= sel_i ? dl_data_i : tx_s_q;
    end
  end

  assign tx_data_o = tx_o_q;
endmodule

// File: rtl/dlgc_gap_clock.sv
module dlgc_gap_clock
  import dlgc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = SLOTS_MAX,
  parameter int unsigned BITS_SLOT   = SLOT_BITS,
  parameter int unsigned SHORT_SLOTS = T1_SLOTS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W  = $clog2(BITS_SLOT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 e1_mode_i,
  input  logic                 frame_start_i,
  input  logic [NUM_SLOTS-1:0] slot_en_i,
  input  logic [BITS_SLOT-1:0] bit_en_i,
  input  logic                 tx_data_i,
  input  logic                 dl_data_i,
  input  logic                 rx_data_i,
  output logic                 gclk_o,
  output logic                 tx_data_o,
  output logic                 rx_data_o,
  output logic                 rx_mark_o
);
  logic              locked_d, fbit_d, sel;
  logic [SLOT_W-1:0] slot_d;
  logic [BIT_W-1:0]  bit_d;
  logic              rx_q;

  dlgc_pos_counter #(
    .NUM_SLOTS(NUM_SLOTS), .BITS_SLOT(BITS_SLOT), .SHORT_SLOTS(SHORT_SLOTS)
  ) u_cnt (
    .clk_i, .rst_ni, .e1_mode_i, .frame_start_i,
    .locked_d_o(locked_d), .fbit_d_o(fbit_d), .slot_d_o(slot_d), .bit_d_o(bit_d)
  );

  dlgc_slot_select #(.NUM_SLOTS(NUM_SLOTS), .BITS_SLOT(BITS_SLOT)) u_sel (
    .clk_i, .rst_ni, .locked_i(locked_d), .fbit_i(fbit_d),
    .slot_i(slot_d), .bit_i(bit_d), .slot_en_i, .bit_en_i, .sel_o(sel)
  );

  dlgc_tx_merge u_tx (
    .clk_i, .rst_ni, .sel_i(sel), .tx_data_i, .dl_data_i, .tx_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_data_i;
  end

  // sel changes only at the rising edge, when ~clk_i is already 0
  assign gclk_o    = sel & ~clk_i;
  assign rx_data_o = rx_q;
  assign rx_mark_o = sel;
endmodule

// File: rtl/dlgc_gap_clock_chk.sv
module dlgc_gap_clock_chk #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned BITS_SLOT = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 e1_mode_i,
  input logic                 frame_start_i,
  input logic [NUM_SLOTS-1:0] slot_en_i,
  input logic [BITS_SLOT-1:0] bit_en_i,
  input logic                 tx_data_i,
  input logic                 dl_data_i,
  input logic                 rx_data_i,
  input logic                 gclk_o,
  input logic                 tx_data_o,
  input logic                 rx_data_o,
  input logic                 rx_mark_o
);
  logic       seen_fs;
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_fs <= 1'b0;
      cyc     <= '0;
    end else begin
      seen_fs <= seen_fs | frame_start_i;
      if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end
  end

  a_r1_quiet_until_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fs |-> !rx_mark_o);
  a_r2_gclk_low_in_high_phase: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !gclk_o);
  a_r3_no_slots_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en_i == '0) |=> !rx_mark_o);
  a_r3_no_bits_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i == '0) |=> !rx_mark_o);
  a_r4_fbit_unmarked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e1_mode_i && frame_start_i) |=> !rx_mark_o);
  a_r7_rx_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0) |=> (rx_data_o == $past(rx_data_i)));
  a_r8_tx_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && !rx_mark_o) |=> (tx_data_o == $past(tx_data_i, 2)));
  a_r8_tx_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mark_o |=> (tx_data_o == $past(dl_data_i)));
endmodule

bind dlgc_gap_clock dlgc_gap_clock_chk #(.NUM_SLOTS(NUM_SLOTS), .BITS_SLOT(BITS_SLOT)) chk_i (.*);

// File: tb/dlgc_gap_clock_tb.sv
module dlgc_gap_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e1 = 1'b1, fs = 1'b0;
  logic [31:0] sen = '0;
  logic [7:0]  ben = '0;
  logic        txd = 1'b0, dld = 1'b0, rxd = 1'b0;
  logic        gclk, tx_o, rx_o, mark;

  int total = 0, bad = 0;
  int pos = -1;
  bit m_sel = 0, m_tx = 0;
  int pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dlgc_gap_clock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .e1_mode_i(e1), .frame_start_i(fs),
    .slot_en_i(sen), .bit_en_i(ben), .tx_data_i(txd), .dl_data_i(dld),
    .rx_data_i(rxd), .gclk_o(gclk), .tx_data_o(tx_o), .rx_data_o(rx_o),
    .rx_mark_o(mark)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_sel(input int p);
    int k;
    if (p < 0) return 0;
    if (!e1) begin
      if (p == 0) return 0;
      k = p - 1;
    end else k = p;
    return sen[k / 8] & ben[k % 8];
  endfunction

  // called in the low phase; presents one bit and checks both phases
  task automatic step(input bit f, input bit t, input bit r, input bit d);
    bit nsel;
    bit pend_tx;
    int len;
    len = e1 ? 256 : 193;
    pend_tx = m_sel ? d : m_tx;
    if (f) pos = 0;
    else if (pos >= 0) pos = (pos + 1) % len;
    nsel = ref_sel(pos);
    fs = f; txd = t; rxd = r; dld = d;
    @(posedge clk); #1;
    chk(gclk == 1'b0, "R2 gclk high phase", gclk, 0);
    chk(mark == nsel, "R3/R4/R7 rx_mark", mark, nsel);
    chk(rx_o == r, "R7 rx_data", rx_o, r);
    chk(tx_o == pend_tx, "R8 tx_data", tx_o, pend_tx);
    m_sel = nsel; m_tx = t;
    @(negedge clk); #1;
    chk(gclk == nsel, "R2/R7 gclk low phase", gclk, nsel);
    if (gclk) pulses++;
  endtask

  task automatic rnd_step(input bit f);
    step(f, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  // one full frame from a marker; R9 pulse count
  task automatic frame_count(input string tag, input int exp_pulses);
    int len;
    len = e1 ? 256 : 193;
    pulses = 0;
    rnd_step(1'b1);
    for (int i = 1; i < len; i++) rnd_step(1'b0);
    chk(pulses == exp_pulses, tag, pulses, exp_pulses);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #5;
    chk(gclk == 0 && tx_o == 0 && rx_o == 0 && mark == 0, "R1 reset outputs",
        {gclk, tx_o, rx_o, mark}, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 all masks on, no marker yet: nothing marked
    sen = '1; ben = '1;
    for (int i = 0; i < 40; i++) rnd_step(1'b0);
    chk(pulses == 0, "R1 no pulse before marker", pulses, 0);

    // R3 E1, first bit only, alternating slots
    e1 = 1'b1; sen = 32'h5555_5555; ben = 8'h01;
    frame_count("R9 E1 16x1", 16);
    // R3 sparse bits, edge slots
    sen = 32'h8000_0001; ben = 8'hA5;
    frame_count("R9 E1 2x4", 8);
    // R5 flywheel: no marker, second frame counted
    pulses = 0;
    for (int i = 0; i < 256; i++) rnd_step(1'b0);
    chk(pulses == 8, "R5 E1 flywheel count", pulses, 8);

    // R4 T1 full masks: 24 slots x 8 bits, framing bit skipped
    e1 = 1'b0; sen = '1; ben = '1;
    frame_count("R9/R4 T1 full", 192);
    // R4 only out-of-range slots enabled
    sen = 32'hFF00_0000;
    frame_count("R4 T1 high slots ignored", 0);
    sen = 32'h0080_0001; ben = 8'h80;
    frame_count("R9 T1 2x1", 2);
    // R5 T1 flywheel
    pulses = 0;
    for (int i = 0; i < 193; i++) rnd_step(1'b0);
    chk(pulses == 2, "R5 T1 flywheel count", pulses, 2);

    // R6 mid-frame restart in E1, then marker on the natural wrap
    e1 = 1'b1; sen = 32'h0000_00F3; ben = 8'h3C;
    rnd_step(1'b1);
    for (int i = 1; i < 100; i++) rnd_step(1'b0);
    pulses = 0;
    rnd_step(1'b1);
    for (int i = 1; i < 256; i++) rnd_step(1'b0);
    chk(pulses == 24, "R6 count after restart", pulses, 24);
    frame_count("R6 marker on wrap", 24);

    // R3 masks cleared mid-stream
    ben = '0;
    for (int i = 0; i < 64; i++) rnd_step(1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule